// File: doc/BRIEF.md
# Receive Queue Congestion Flow Controller

This block watches how full a receive buffer queue is and starts link-level flow control when the fill level reaches a programmable upper threshold. It releases flow control only when the level drops below a separate, lower threshold. The gap between the two thresholds keeps the controller from switching on and off rapidly.

The programmed duplex setting decides how flow control is applied:

- **Half duplex.** The block raises a back-pressure output for as long as the queue is congested. The line logic uses it to make the medium look busy to the link partner.
- **Full duplex.** The block asks the transmit path to send a PAUSE control frame that carries a programmable 16-bit quanta.
  - It only raises a request while the transmitter reports that it is idle between frames, and it keeps the request steady until the transmitter reports the frame as sent.
  - While congestion lasts, it renews the PAUSE on a programmable period so the partner's pause time does not run out.
  - When congestion ends, it requests a PAUSE with quanta zero. If the partner was never paused, it drops the request that had not yet been sent.

A sticky status flag is set at each congestion onset and cleared by a host write of one.

Top module: `rxq_flow_ctrl`

## Requirements
- R1: After reset, `congested`, `backpressure`, `pause_req` and `status_flag` are all 0.
- R2: When `congested` is 0 and `level >= thr_high`, `congested` becomes 1 on the next clock edge. While `level < thr_high`, it stays 0.
- R3: Once set, `congested` stays 1 while `level >= thr_low`. It clears on the first edge at which `level < thr_low`.
- R4: With `full_duplex` = 0, `backpressure` equals `congested`, and `pause_req` stays 0.
- R5: With `full_duplex` = 1, `backpressure` stays 0. A congestion onset leads to a request with `pause_value` equal to `pause_quanta`.
- R6: `pause_req` rises only on an edge at which `tx_idle` was 1. Once raised, `pause_req` and `pause_value` hold steady until the edge that samples `pause_done` = 1, after which `pause_req` is 0.
- R7: While congested in full duplex, after a nonzero pause completes, the next request with `pause_quanta` becomes visible exactly `refresh_period`+1 edges after the `pause_done` edge, provided `tx_idle` is 1.
- R8: When congestion clears in full duplex after a nonzero pause was sent, a request with `pause_value` = 0 is made.
- R9: If congestion clears before a pending nonzero pause has been launched, and no nonzero pause has completed, the request is cancelled and `pause_req` stays 0.
- R10: `status_flag` is set on the edge at which congestion starts. A `status_clr` of 1 clears it on the next edge, even while still congested. On the same edge, an onset wins over a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| level | input | LVL_W | Current queue fill level |
| thr_high | input | LVL_W | Level at or above which congestion starts |
| thr_low | input | LVL_W | Level below which congestion ends |
| full_duplex | input | 1 | 1 selects PAUSE frames, 0 selects back-pressure |
| pause_quanta | input | 16 | Pause time carried in congestion PAUSE requests |
| refresh_period | input | CNT_W | Cycles between PAUSE renewals (at least 1) |
| tx_idle | input | 1 | Transmitter is between frames |
| pause_done | input | 1 | Transmitter has finished the requested PAUSE frame |
| status_clr | input | 1 | Host write-one-to-clear of the status flag |
| congested | output | 1 | Live congestion state |
| backpressure | output | 1 | Force the line busy (half duplex) |
| pause_req | output | 1 | Request to send a PAUSE frame |
| pause_value | output | 16 | Quanta for the requested PAUSE frame |
| status_flag | output | 1 | Sticky congestion indication |

## Verification
The assertions assume the following about the inputs:
- `pause_done` is raised only while a request is outstanding.
- `thr_low` is no greater than `thr_high`.
- `refresh_period` is at least one.
- `full_duplex` does not change during a congestion episode.

The directed stimulus follows all of these rules. It changes every input just after a falling edge, raises the transmitter handshakes only in response to a visible request, and switches the duplex setting only between tests, when the queue is empty and no request is pending.

// File: rtl/rxq_flow_ctrl.sv
module rxq_flow_ctrl #(
  parameter int LVL_W = 12,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] thr_high,
  input  logic [LVL_W-1:0] thr_low,
  input  logic             full_duplex,
  input  logic [15:0]      pause_quanta,
  input  logic [CNT_W-1:0] refresh_period,
  input  logic             tx_idle,
  input  logic             pause_done,
  input  logic             status_clr,
  output logic             congested,
  output logic             backpressure,
  output logic             pause_req,
  output logic [15:0]      pause_value,
  output logic             status_flag
);

  logic             cong_q, flag_q;
  logic             want_q, active_q, paused_q;
  logic [15:0]      want_val_q, act_val_q;
  logic [CNT_W-1:0] cnt_q;

  wire hit_high  = level >= thr_high;
  wire below_low = level < thr_low;
  wire onset     = !cong_q && hit_high;
  wire release_c = cong_q && below_low;
  wire launch    = want_q && !active_q && tx_idle;
  wire finish    = active_q && pause_done;
  wire cnt_run   = cong_q && full_duplex && paused_q && !active_q && !want_q && !release_c;
  wire tick      = cnt_run && (cnt_q == refresh_period - 1'b1);
  wire need_zero = paused_q || (active_q && act_val_q != '0) || (launch && want_val_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cong_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (onset)          cong_q <= 1'b1;
      else if (release_c) cong_q <= 1'b0;
      if (onset)           flag_q <= 1'b1;
      else if (status_clr) flag_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      want_q     <= 1'b0;
      want_val_q <= '0;
    end else if (!full_duplex) begin
      want_q <= 1'b0;
    end else if (onset || tick) begin
      want_q     <= 1'b1;
      want_val_q <= pause_quanta;
    end else if (release_c) begin
      want_q     <= need_zero;
      want_val_q <= '0;
    end else if (launch) begin
      want_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      act_val_q <= '0;
      paused_q  <= 1'b0;
    end else if (launch) begin
      active_q  <= 1'b1;
      act_val_q <= want_val_q;
    end else if (finish) begin
      active_q <= 1'b0;
      paused_q <= act_val_q != '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (cnt_run && !tick) cnt_q <= cnt_q + 1'b1;
    else                       cnt_q <= '0;
  end

  assign congested    = cong_q;
  assign backpressure = cong_q && !full_duplex;
  assign pause_req    = active_q;
  assign pause_value  = act_val_q;
  assign status_flag  = flag_q;

endmodule

module rxq_flow_ctrl_chk #(
  parameter int LVL_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LVL_W-1:0] level,
  input logic [LVL_W-1:0] thr_high,
  input logic [LVL_W-1:0] thr_low,
  input logic             tx_idle,
  input logic             pause_done,
  input logic             congested,
  input logic             pause_req,
  input logic [15:0]      pause_value,
  input logic             status_flag
);

  assert_stay_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!congested && level < thr_high) |=> !congested);

  assert_hold_hyst_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (congested && level >= thr_low) |=> congested);

  assert_launch_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pause_req) |-> $past(tx_idle));

  assert_req_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_req && !pause_done) |=> (pause_req && $stable(pause_value)));

  assert_flag_onset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(congested) |-> status_flag);

endmodule

bind rxq_flow_ctrl rxq_flow_ctrl_chk #(.LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .level(level), .thr_high(thr_high), .thr_low(thr_low),
  .tx_idle(tx_idle), .pause_done(pause_done), .congested(congested),
  .pause_req(pause_req), .pause_value(pause_value), .status_flag(status_flag)
);

// File: tb/rxq_flow_ctrl_test.sv
module rxq_flow_ctrl_test;
  localparam int LVL_W = 12;
  localparam int CNT_W = 16;
  localparam int PER   = 20;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [LVL_W-1:0] level = '0;
  logic [LVL_W-1:0] thr_high = 12'd100;
  logic [LVL_W-1:0] thr_low = 12'd60;
  logic             full_duplex = 1'b0;
  logic [15:0]      pause_quanta = 16'h1234;
  logic [CNT_W-1:0] refresh_period = CNT_W'(PER);
  logic             tx_idle = 1'b0;
  logic             pause_done = 1'b0;
  logic             status_clr = 1'b0;
  logic             congested, backpressure, pause_req, status_flag;
  logic [15:0]      pause_value;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  rxq_flow_ctrl #(.LVL_W(LVL_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .level(level), .thr_high(thr_high), .thr_low(thr_low),
    .full_duplex(full_duplex), .pause_quanta(pause_quanta), .refresh_period(refresh_period),
    .tx_idle(tx_idle), .pause_done(pause_done), .status_clr(status_clr),
    .congested(congested), .backpressure(backpressure), .pause_req(pause_req),
    .pause_value(pause_value), .status_flag(status_flag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic done_pulse();
    pause_done = 1'b1;
    step();
    pause_done = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 congested", congested, 0);
    chk("R1 backpressure", backpressure, 0);
    chk("R1 pause_req", pause_req, 0);
    chk("R1 status_flag", status_flag, 0);
  endtask

  task automatic t_half();
    full_duplex = 1'b0; tx_idle = 1'b1;
    level = 12'd99; step();
    chk("R2 below high", congested, 0);
    level = 12'd100; step();
    chk("R2 onset", congested, 1);
    chk("R4 backpressure on", backpressure, 1);
    chk("R10 flag set", status_flag, 1);
    level = 12'd60; step(); step();
    chk("R3 hold at low", congested, 1);
    chk("R4 no pause in half", pause_req, 0);
    level = 12'd59; step();
    chk("R3 release", congested, 0);
    chk("R4 backpressure off", backpressure, 0);
    level = 12'd0; step();
  endtask

  task automatic t_flag();
    chk("R10 sticky", status_flag, 1);
    status_clr = 1'b1; step(); status_clr = 1'b0;
    chk("R10 cleared", status_flag, 0);
    level = 12'd120; status_clr = 1'b1; step(); status_clr = 1'b0;
    chk("R10 onset wins", status_flag, 1);
    status_clr = 1'b1; step(); status_clr = 1'b0;
    chk("R10 clear while congested", status_flag, 0);
    chk("R10 still congested", congested, 1);
    level = 12'd0; step(); step();
  endtask

  task automatic t_full();
    int n;
    full_duplex = 1'b1; tx_idle = 1'b0;
    level = 12'd150; step();
    chk("R5 congested", congested, 1);
    chk("R5 no backpressure", backpressure, 0);
    repeat (4) step();
    chk("R6 wait for idle", pause_req, 0);
    tx_idle = 1'b1; step();
    chk("R5 request", pause_req, 1);
    chk("R5 quanta", pause_value, 32'h1234);
    tx_idle = 1'b0; repeat (3) step();
    chk("R6 held", pause_req, 1);
    chk("R6 value held", pause_value, 32'h1234);
    done_pulse();
    chk("R6 dropped after done", pause_req, 0);
    tx_idle = 1'b1;
    n = 0;
    while (!pause_req && n < 60) begin step(); n++; end
    chk("R7 refresh interval", n, PER + 1);
    chk("R7 refresh quanta", pause_value, 32'h1234);
    done_pulse();
    level = 12'd80; step();
    chk("R3 hold in full", congested, 1);
    level = 12'd10; step();
    chk("R3 release in full", congested, 0);
    step();
    chk("R8 resume request", pause_req, 1);
    chk("R8 resume zero", pause_value, 0);
    done_pulse();
    n = 0;
    repeat (30) begin step(); if (pause_req) n++; end
    chk("R8 no more requests", n, 0);
  endtask

  task automatic t_cancel();
    int n;
    full_duplex = 1'b1; tx_idle = 1'b0;
    level = 12'd200; step();
    chk("R9 congested", congested, 1);
    level = 12'd0; step();
    chk("R9 released", congested, 0);
    tx_idle = 1'b1;
    n = 0;
    repeat (10) begin step(); if (pause_req) n++; end
    chk("R9 cancelled", n, 0);
  endtask

  initial begin
    repeat (3) step();
    t_reset();
    rst_n = 1'b1;
    step();
    t_reset();
    t_half();
    t_flag();
    t_full();
    t_cancel();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule